// File: doc/BRIEF.md
# Word-Wide Fuse Array Reader with Byte Trimming

This block sits between a byte-oriented requester and a one-time-programmable fuse array that delivers 32 bits per read access. A request gives a starting byte offset and a byte count. The reader reads every 32-bit word that the byte span touches, in ascending order. For each word it raises the array's strobe and loads the word address in a single update of the control word. It captures the array output at the end of the strobe and then streams out only the wanted bytes, one byte per cycle.

The leading bytes of the first word and the trailing bytes of the last word are dropped. All waits are one microsecond long, and their length in clock cycles is set by a parameter. When a request finishes, the array is put into a power-down standby state and a one-cycle done pulse is given. The array model is not part of the block. Programming the fuses, bus access and clock control are not included.

Top module: `fuse_word_reader`

## Requirements
- R1: After reset the control word `fuse_ctrl` is 0x21, which is power-down (bit 5) plus chip-select-bar (bit 0) with every other bit low. After reset `busy`, `done` and `byte_valid` are all low.
- R2: `req_valid` with a nonzero `req_len` is accepted when the block is idle. In the next cycle `busy` is high and `fuse_ctrl` is 0x28C: load (bit 2), program-enable-bar (bit 3), read-select-bar (bit 7) and strobe-shift-select (bit 9), with the address field zero. The first strobe rises exactly CYC_PER_US cycles after `busy` rises.
- R3: The words read run from floor(offset/4) to ceil((offset+len)/4)-1, in ascending order, with one strobe pulse each. Each word address fully replaces bits 25:16 of the control word and wraps modulo 2^ADDR_W.
- R4: Strobe (bit 1) and the new address appear in the same cycle. Strobe stays high for exactly CYC_PER_US cycles. After strobe falls, it stays low for at least CYC_PER_US cycles before the next strobe.
- R5: Each captured word is split into bytes with the least significant byte first. Output starts at byte position offset mod 4 of the first word. Exactly `req_len` bytes are delivered, one per `byte_valid` cycle.
- R6: After the last word, `fuse_ctrl` returns to 0x21 in the same cycle that `busy` falls. `done` is high for exactly that one cycle.
- R7: A request with `req_len` of zero produces no strobe and does not raise `busy`. It pulses `done` in the cycle after the request, and `fuse_ctrl` stays at 0x21.
- R8: `req_valid` while `busy` is high is ignored. The byte stream and the word sequence of the running request do not change.
- R9: `byte_valid` is never high while strobe is high, and never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (taken only when idle) |
| req_offset | input | ADDR_W+2 | Starting byte offset |
| req_len | input | LEN_W | Number of bytes to return |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| byte_valid | output | 1 | `byte_data` holds a returned byte |
| byte_data | output | 8 | Returned byte |
| fuse_ctrl | output | 32 | Control word driven to the fuse array |
| fuse_dout | input | 32 | Word output of the fuse array |

## Verification
The bench builds the reader with CYC_PER_US=3, ADDR_W=4 and LEN_W=7. The short wait keeps each strobe and gap only a few cycles long, so many requests fit in a short run. With a 16-word array, the offsets near the top word can be reached, and so can requests that wrap the word address back to zero. The largest length, 127, sweeps the whole array almost twice and checks that each address fully replaces the previous one in the field.

// File: rtl/fuse_word_reader.sv
module fuse_word_reader #(
  parameter int CYC_PER_US = 100,
  parameter int ADDR_W     = 10,
  parameter int LEN_W      = 12,
  localparam int OFS_W     = ADDR_W + 2,
  localparam int CNT_W     = $clog2(CYC_PER_US + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [31:0]      fuse_ctrl,
  input  logic [31:0]      fuse_dout
);

  localparam logic [31:0] CTRL_STANDBY = 32'h0000_0021;
  localparam logic [31:0] CTRL_READ    = 32'h0000_028C;
  localparam logic [31:0] STROBE_BIT   = 32'h0000_0002;
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(CYC_PER_US - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_EMIT, S_LOW} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] waddr;
  logic [1:0]       sel;
  logic [LEN_W-1:0] remain;
  logic [31:0]      hold;

  function automatic logic [31:0] addr_field(input logic [ADDR_W-1:0] a);
    logic [31:0] f;
    f = '0;
    f[16 +: ADDR_W] = a;
    return f;
  endfunction

  assign busy       = (state != S_IDLE);
  assign byte_valid = (state == S_EMIT);
  assign byte_data  = hold[{sel, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      fuse_ctrl <= CTRL_STANDBY;
      done      <= 1'b0;
      cnt       <= '0;
      waddr     <= '0;
      sel       <= '0;
      remain    <= '0;
      hold      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              state     <= S_SETUP;
              fuse_ctrl <= CTRL_READ;
              cnt       <= WAIT_LAST;
              waddr     <= req_offset[OFS_W-1:2];
              sel       <= req_offset[1:0];
              remain    <= req_len;
            end
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            state     <= S_STROBE;
            fuse_ctrl <= CTRL_READ | STROBE_BIT | addr_field(waddr);
            cnt       <= WAIT_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_STROBE: begin
          if (cnt == '0) begin
            hold      <= fuse_dout;
            fuse_ctrl <= fuse_ctrl & ~STROBE_BIT;
            state     <= S_EMIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_EMIT: begin
          remain <= remain - 1'b1;
          sel    <= sel + 1'b1;
          if (remain == LEN_W'(1) || sel == 2'd3) begin
            state <= S_LOW;
            cnt   <= WAIT_LAST;
            waddr <= waddr + 1'b1;
          end
        end
        S_LOW: begin
          if (cnt == '0) begin
            if (remain == '0) begin
              state     <= S_IDLE;
              fuse_ctrl <= CTRL_STANDBY;
              done      <= 1'b1;
            end else begin
              state     <= S_STROBE;
              fuse_ctrl <= CTRL_READ | STROBE_BIT | addr_field(waddr);
              cnt       <= WAIT_LAST;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fuse_word_reader_chk.sv
module fuse_word_reader_chk #(
  parameter int CYC_PER_US = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        byte_valid,
  input logic [31:0] fuse_ctrl
);

  logic strobe;
  logic [31:0] hi_cnt;
  assign strobe = fuse_ctrl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (strobe) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= '0;
  end

  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> fuse_ctrl == 32'h21); // R1
  AST_STROBE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (fuse_ctrl[15:0] == 16'h028E) && busy); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> $stable(fuse_ctrl[25:16])); // R3
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> hi_cnt == CYC_PER_US); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_NO_BYTE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !strobe && busy); // R9

endmodule

bind fuse_word_reader fuse_word_reader_chk #(.CYC_PER_US(CYC_PER_US)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .byte_valid(byte_valid), .fuse_ctrl(fuse_ctrl)
);

// File: tb/fuse_word_reader_tb_top.sv
module fuse_word_reader_tb_top;
  localparam int CYC = 3;
  localparam int AW  = 4;
  localparam int LW  = 7;
  localparam int OW  = AW + 2;
  localparam int NBYTES = 1 << OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [OW-1:0] req_offset = '0;
  logic [LW-1:0] req_len = '0;
  logic busy, done, byte_valid;
  logic [7:0] byte_data;
  logic [31:0] fuse_ctrl, fuse_dout;

  always #5 clk = ~clk;

  fuse_word_reader #(.CYC_PER_US(CYC), .ADDR_W(AW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_len(req_len), .busy(busy), .done(done), .byte_valid(byte_valid),
    .byte_data(byte_data), .fuse_ctrl(fuse_ctrl), .fuse_dout(fuse_dout)
  );

  function automatic logic [7:0] fbyte(input int i);
    return 8'(((i % NBYTES) * 37) + 11);
  endfunction

  always_comb begin
    int a;
    a = int'(fuse_ctrl[25:16]);
    fuse_dout = fuse_ctrl[1] ? {fbyte(4*a+3), fbyte(4*a+2), fbyte(4*a+1), fbyte(4*a)} : 32'h0;
  end

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] got_q[$];
  int addr_q[$];
  int strobes = 0, width_bad = 0, gap_bad = 0, hi = 0, lo = 0;
  int t_busy = -1, t_first = -1;
  logic prev_s = 1'b0, prev_b = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (byte_valid) got_q.push_back(byte_data);
    if (busy && !prev_b) t_busy = cyc;
    if (fuse_ctrl[1] && !prev_s) begin
      if (strobes > 0 && lo < CYC) gap_bad++;
      if (strobes == 0) t_first = cyc;
      strobes++;
      addr_q.push_back(int'(fuse_ctrl[25:16]));
      hi = 1;
    end else if (fuse_ctrl[1]) hi++;
    if (!fuse_ctrl[1] && prev_s) begin
      if (hi != CYC) width_bad++;
      lo = 1;
    end else if (!fuse_ctrl[1]) lo++;
    prev_s = fuse_ctrl[1];
    prev_b = busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int off, input int len, input bit inject);
    int words, first, mism, waited;
    @(negedge clk);
    got_q.delete(); addr_q.delete();
    strobes = 0; width_bad = 0; gap_bad = 0; t_busy = -1; t_first = -1;
    req_offset = OW'(off); req_len = LW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len > 0) begin
      check(busy && fuse_ctrl == 32'h28C, "R2 setup word", int'(fuse_ctrl), 32'h28C);
      if (inject) begin
        repeat (2*CYC + 2) @(negedge clk);
        req_offset = OW'(off + 9); req_len = LW'(3); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check(done, "R6 done seen (watchdog)", int'(done), 1);
    check(!busy && fuse_ctrl == 32'h21, "R6 standby at done", int'(fuse_ctrl), 32'h21);
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    first = off / 4;
    words = (len == 0) ? 0 : (off + len + 3) / 4 - first;
    if (len == 0) begin
      check(strobes == 0 && t_busy == -1, "R7 no strobe no busy", strobes, 0);
    end else begin
      check(t_first - t_busy == CYC, "R2 setup wait", t_first - t_busy, CYC);
      check(width_bad == 0 && gap_bad == 0, "R4 strobe width/gap", width_bad + gap_bad, 0);
    end
    check(strobes == words, inject ? "R8 word count" : "R3 word count", strobes, words);
    mism = 0;
    foreach (addr_q[k]) if (addr_q[k] != (first + k) % (1 << AW)) mism++;
    check(mism == 0, "R3 address order", mism, 0);
    check(got_q.size() == len, inject ? "R8 byte count" : "R5 byte count", got_q.size(), len);
    mism = 0;
    foreach (got_q[k]) if (got_q[k] != fbyte(off + k)) mism++;
    check(mism == 0, inject ? "R8 byte values" : "R5 byte values", mism, 0);
  endtask

  localparam int NV = 9;
  localparam int V_OFS[NV] = '{0, 1, 3, 2, 5, 0, 7, 62, 13};
  localparam int V_LEN[NV] = '{4, 1, 2, 7, 12, 1, 9, 5, 40};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fuse_ctrl == 32'h21 && !busy && !done && !byte_valid, "R1 reset state",
          int'(fuse_ctrl), 32'h21);
    for (int v = 0; v < NV; v++) run(V_OFS[v], V_LEN[v], 1'b0);
    run(6, 0, 1'b0);   // R7 zero length
    run(10, 11, 1'b1); // R8 request while busy
    run(3, 127, 1'b0); // R3 wrap, R5 maximum length
    run(63, 1, 1'b0);  // R5 last byte of top word
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule